// File: doc/BRIEF.md
# Sorted Tag List with Crosspoint Exchange

This block sits at one input of a buffered crossbar. It keeps a list of up to 16 cell tags in order of departure time, plus one crosspoint register for each of the 4 outputs. The list is what an output-queued switch with delay guarantees would serve. Each tag carries an 8-bit departure time and a 2-bit output number. The list is read from the head. An arriving tag goes into the list at the place its departure time dictates, so it need not wait behind later cells for the same output.

A load request moves one listed tag into its output's crosspoint. The tag moved is the head-most one whose crosspoint is free. A drain request empties one crosspoint; the scheduler that drains crosspoints sits outside this block. In the cycle after an arrival, the block compares the new tag with the tag already in that output's crosspoint. If the new tag must leave earlier, the two swap: the urgent tag takes the crosspoint and the displaced tag goes back into the list at its sorted place. The whole list and all crosspoints are visible on the outputs. Only the first `list_cnt` list slots hold meaningful entries.

Top module: `pifo_xp_top`

## Requirements
- R1: After reset the list count is 0, no crosspoint is valid and `busy` is low.
- R2: An accepted arrival is inserted after every listed tag whose departure time is less than or equal to its own. The list therefore stays non-decreasing from slot 0 (the head), and tags with equal times keep arrival order.
- R3: An arrival while the list holds 16 tags is dropped and leaves the list unchanged.
- R4: `busy` is high for exactly the one cycle after an accepted arrival. In that cycle, arrival, load and drain requests are all ignored.
- R5: During the busy cycle, if the arrival's output has a valid crosspoint with a strictly larger time, the crosspoint takes the arrival's time. The displaced tag replaces the arrival in the list at its sorted position, and the count is unchanged.
- R6: During the busy cycle, no exchange occurs if that crosspoint is empty or holds a time less than or equal to the arrival's time.
- R7: A load removes the lowest-slot listed tag whose output crosspoint is empty and places it in that crosspoint, lowering the count by one. If no listed tag qualifies, the load has no effect.
- R8: A drain clears the crosspoint of `drain_dst` and leaves the list unchanged.
- R9: Outside the busy cycle, at most one operation occurs per cycle, in the priority arrival, then load, then drain. A cycle with `arr_valid` high performs no load or drain, even if the arrival is dropped.
- R10: Whenever `busy` is low, each valid crosspoint time is less than or equal to every listed time for the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid | input | 1 | Arrival request |
| arr_dep | input | 8 | Departure time of the arriving tag |
| arr_dst | input | 2 | Output number of the arriving tag |
| load_req | input | 1 | Move the head-most eligible tag into its crosspoint |
| drain_req | input | 1 | Empty one crosspoint |
| drain_dst | input | 2 | Output whose crosspoint is emptied |
| busy | output | 1 | Exchange cycle in progress; requests ignored |
| list_cnt | output | 5 | Number of listed tags |
| list_dep | output | 128 | Departure times, slot i at bits [8i+7:8i], slot 0 is the head |
| list_dst | output | 32 | Output numbers, slot i at bits [2i+1:2i] |
| xp_valid | output | 4 | Crosspoint occupied flags, bit o for output o |
| xp_dep | output | 32 | Crosspoint departure times, output o at bits [8o+7:8o] |

## Verification
The assertions assume that departure times do not wrap within a run, so that plain unsigned comparison gives the service order. The stimulus draws times from the full 8-bit range but never reinterprets them as a wrapped sequence. The ordering check after each exchange also assumes the scheduler only empties crosspoints through the drain port. The bench therefore touches crosspoints only through drain requests, and it issues requests in busy cycles solely to confirm that they are ignored.

// File: rtl/pifo_xp_pkg.sv
package pifo_xp_pkg;
  parameter int unsigned TIME_W = 8;
  parameter int unsigned N_OUT  = 4;
  parameter int unsigned DST_W  = $clog2(N_OUT);

  typedef struct packed {
    logic [TIME_W-1:0] dep;
    logic [DST_W-1:0]  dst;
  } tag_t;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ARRIVE,
    OP_DROP,
    OP_LOAD,
    OP_DRAIN,
    OP_EXCHANGE
  } op_e;
endpackage

// File: rtl/pifo_sorted_list.sv
module pifo_sorted_list
  import pifo_xp_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  tag_t             ins_tag,
  input  logic             rm_en,
  input  logic [IDX_W-1:0] rm_idx,
  output logic [IDX_W-1:0] ins_pos,
  output tag_t             ent [DEPTH],
  output logic [CNT_W-1:0] cnt
);

  tag_t             ent_q [DEPTH];
  tag_t             ent_n [DEPTH];
  tag_t             cmp   [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] ccnt;
  logic [CNT_W-1:0] pos;
  logic             upd;

  // compaction: slots at or behind the removed one move up by one
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    if (i == DEPTH - 1) begin : g_last
      assign cmp[i] = (rm_en && (IDX_W'(i) >= rm_idx)) ? '0 : ent_q[i];
    end else begin : g_mid
      assign cmp[i] = (rm_en && (IDX_W'(i) >= rm_idx)) ? ent_q[i+1] : ent_q[i];
    end
  end

  always_comb begin
    ccnt = cnt_q - CNT_W'(rm_en);
    pos  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < ccnt) && (cmp[i].dep <= ins_tag.dep)) pos = pos + CNT_W'(1);
    end
  end

  assign ins_pos = pos[IDX_W-1:0];

  // insertion: slots at or behind the insertion point move down by one
  for (genvar i = 0; i < DEPTH; i++) begin : g_ins
    if (i == 0) begin : g_head
      assign ent_n[i] = (ins_en && (pos == '0)) ? ins_tag : cmp[i];
    end else begin : g_tail
      always_comb begin
        if (!ins_en || (CNT_W'(i) < pos)) ent_n[i] = cmp[i];
        else if (CNT_W'(i) == pos)        ent_n[i] = ins_tag;
        else                               ent_n[i] = cmp[i-1];
      end
    end
  end

  assign cnt_n = ccnt + CNT_W'(ins_en);
  assign upd   = ins_en | rm_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (upd) begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
    end
  end

  assign ent = ent_q;
  assign cnt = cnt_q;

  logic sorted_ok;
  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if ((CNT_W'(i + 1) < cnt_q) && (ent_q[i].dep > ent_q[i+1].dep)) sorted_ok = 1'b0;
    end
  end

  // R2
  sorted_chk: assert property (@(posedge clk) disable iff (!rst_n) sorted_ok);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !rm_en) |-> (cnt_q < CNT_W'(DEPTH)));

  // R7
  rm_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |-> (CNT_W'(rm_idx) < cnt_q));

endmodule

// File: rtl/pifo_xp_bank.sv
module pifo_xp_bank
  import pifo_xp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tag_t              wr_tag,
  input  logic              clr_en,
  input  logic [DST_W-1:0]  clr_dst,
  output logic [N_OUT-1:0]  xp_v,
  output logic [TIME_W-1:0] xp_dep [N_OUT]
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_xp
    logic              wr_hit;
    logic              clr_hit;
    logic              v_q;
    logic              v_n;
    logic [TIME_W-1:0] dep_q;

    assign wr_hit  = wr_en  && (wr_tag.dst == DST_W'(o));
    assign clr_hit = clr_en && (clr_dst    == DST_W'(o));

    always_comb begin
      v_n = v_q;
      if (wr_hit)       v_n = 1'b1;
      else if (clr_hit) v_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dep_q <= '0;
      else if (wr_hit) dep_q <= wr_tag.dep;
    end

    assign xp_v[o]   = v_q;
    assign xp_dep[o] = dep_q;
  end

  // R8
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && clr_en));

endmodule

// File: rtl/pifo_xp_ctrl.sv
module pifo_xp_ctrl
  import pifo_xp_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  tag_t              arr_tag,
  input  logic              load_req,
  input  logic              drain_req,
  input  logic [DST_W-1:0]  drain_dst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [IDX_W-1:0]  ins_pos,
  input  tag_t              ent [DEPTH],
  input  logic [N_OUT-1:0]  xp_v,
  input  logic [TIME_W-1:0] xp_dep [N_OUT],
  output logic              ins_en,
  output tag_t              ins_tag,
  output logic              rm_en,
  output logic [IDX_W-1:0]  rm_idx,
  output logic              wr_en,
  output tag_t              wr_tag,
  output logic              clr_en,
  output logic [DST_W-1:0]  clr_dst,
  output logic              busy
);

  logic             busy_q;
  logic             busy_n;
  tag_t             p_tag_q;
  logic [IDX_W-1:0] p_idx_q;
  logic             accept;
  logic             room;
  logic             found;
  logic [IDX_W-1:0] fidx;
  logic             swap_hit;
  op_e              op;

  assign room = (cnt < CNT_W'(DEPTH));

  // head-most listed tag whose crosspoint is free
  always_comb begin
    found = 1'b0;
    fidx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < cnt) && !xp_v[ent[i].dst]) begin
        found = 1'b1;
        fidx  = IDX_W'(i);
      end
    end
  end

  assign swap_hit = xp_v[p_tag_q.dst] && (xp_dep[p_tag_q.dst] > p_tag_q.dep);

  always_comb begin
    if (busy_q)                op = swap_hit ? OP_EXCHANGE : OP_IDLE;
    else if (arr_valid)        op = room ? OP_ARRIVE : OP_DROP;
    else if (load_req && found) op = OP_LOAD;
    else if (load_req)         op = OP_IDLE;
    else if (drain_req)        op = OP_DRAIN;
    else                       op = OP_IDLE;
  end

  always_comb begin
    ins_en  = 1'b0;
    ins_tag = arr_tag;
    rm_en   = 1'b0;
    rm_idx  = fidx;
    wr_en   = 1'b0;
    wr_tag  = ent[fidx];
    clr_en  = 1'b0;
    clr_dst = drain_dst;
    case (op)
      OP_ARRIVE: ins_en = 1'b1;
      OP_LOAD: begin
        rm_en = 1'b1;
        wr_en = 1'b1;
      end
      OP_DRAIN: clr_en = 1'b1;
      OP_EXCHANGE: begin
        rm_en       = 1'b1;
        rm_idx      = p_idx_q;
        ins_en      = 1'b1;
        ins_tag.dep = xp_dep[p_tag_q.dst];
        ins_tag.dst = p_tag_q.dst;
        wr_en       = 1'b1;
        wr_tag      = p_tag_q;
      end
      default: ;
    endcase
  end

  assign accept = (op == OP_ARRIVE);
  assign busy_n = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_tag_q <= '0;
      p_idx_q <= '0;
    end else if (accept) begin
      p_tag_q <= arr_tag;
      p_idx_q <= ins_pos;
    end
  end

  assign busy = busy_q;

  // R4
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_q |=> !busy_q);

  // R5
  swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cnt == $past(cnt)));

  // R7
  load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy_q) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R9
  arrive_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && arr_valid) |-> !(rm_en || clr_en));

endmodule

// File: rtl/pifo_xp_top.sv
module pifo_xp_top
  import pifo_xp_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      arr_valid,
  input  logic [TIME_W-1:0]         arr_dep,
  input  logic [DST_W-1:0]          arr_dst,
  input  logic                      load_req,
  input  logic                      drain_req,
  input  logic [DST_W-1:0]          drain_dst,
  output logic                      busy,
  output logic [CNT_W-1:0]          list_cnt,
  output logic [DEPTH*TIME_W-1:0]   list_dep,
  output logic [DEPTH*DST_W-1:0]    list_dst,
  output logic [N_OUT-1:0]          xp_valid,
  output logic [N_OUT*TIME_W-1:0]   xp_dep
);

  tag_t              arr_tag;
  tag_t              ins_tag;
  tag_t              wr_tag;
  tag_t              ent [DEPTH];
  logic              ins_en;
  logic              rm_en;
  logic              wr_en;
  logic              clr_en;
  logic [IDX_W-1:0]  rm_idx;
  logic [IDX_W-1:0]  ins_pos;
  logic [DST_W-1:0]  clr_dst;
  logic [CNT_W-1:0]  cnt;
  logic [N_OUT-1:0]  xv;
  logic [TIME_W-1:0] xd [N_OUT];

  assign arr_tag.dep = arr_dep;
  assign arr_tag.dst = arr_dst;

  pifo_sorted_list #(.DEPTH(DEPTH)) u_list (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_en  (ins_en),
    .ins_tag (ins_tag),
    .rm_en   (rm_en),
    .rm_idx  (rm_idx),
    .ins_pos (ins_pos),
    .ent     (ent),
    .cnt     (cnt)
  );

  pifo_xp_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_tag  (wr_tag),
    .clr_en  (clr_en),
    .clr_dst (clr_dst),
    .xp_v    (xv),
    .xp_dep  (xd)
  );

  pifo_xp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arr_valid (arr_valid),
    .arr_tag   (arr_tag),
    .load_req  (load_req),
    .drain_req (drain_req),
    .drain_dst (drain_dst),
    .cnt       (cnt),
    .ins_pos   (ins_pos),
    .ent       (ent),
    .xp_v      (xv),
    .xp_dep    (xd),
    .ins_en    (ins_en),
    .ins_tag   (ins_tag),
    .rm_en     (rm_en),
    .rm_idx    (rm_idx),
    .wr_en     (wr_en),
    .wr_tag    (wr_tag),
    .clr_en    (clr_en),
    .clr_dst   (clr_dst),
    .busy      (busy)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_list_out
    assign list_dep[i*TIME_W +: TIME_W] = ent[i].dep;
    assign list_dst[i*DST_W +: DST_W]   = ent[i].dst;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_xp_out
    assign xp_dep[o*TIME_W +: TIME_W] = xd[o];
  end

  assign xp_valid = xv;
  assign list_cnt = cnt;

  logic bound_ok;
  always_comb begin
    bound_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < cnt) && xv[ent[i].dst] && (xd[ent[i].dst] > ent[i].dep)) bound_ok = 1'b0;
    end
  end

  // R10
  xp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> bound_ok);

  // R8
  drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !busy && !arr_valid && !load_req) |=> !xp_valid[$past(drain_dst)]);

endmodule

// File: tb/pifo_xp_top_bench.sv
`timescale 1ns/1ps
module pifo_xp_top_bench;
  localparam int DEPTH = 16;
  localparam int NO    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        arr_valid;
  logic [7:0]  arr_dep;
  logic [1:0]  arr_dst;
  logic        load_req;
  logic        drain_req;
  logic [1:0]  drain_dst;
  logic        busy;
  logic [4:0]  list_cnt;
  logic [127:0] list_dep;
  logic [31:0] list_dst;
  logic [3:0]  xp_valid;
  logic [31:0] xp_dep;

  always #2 clk = ~clk;

  pifo_xp_top u_pifo_xp_top (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dep(arr_dep), .arr_dst(arr_dst),
    .load_req(load_req), .drain_req(drain_req), .drain_dst(drain_dst), .busy(busy),
    .list_cnt(list_cnt), .list_dep(list_dep), .list_dst(list_dst),
    .xp_valid(xp_valid), .xp_dep(xp_dep)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  int mt [DEPTH];
  int mo [DEPTH];
  int mcnt;
  bit xv [NO];
  int xt [NO];
  bit mbusy;
  int pt, po, pidx;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_remove(int idx);
    for (int j = idx; j < mcnt - 1; j++) begin
      mt[j] = mt[j+1];
      mo[j] = mo[j+1];
    end
    mcnt--;
  endtask

  function automatic int m_insert(int t, int o);
    int p = 0;
    for (int j = 0; j < mcnt; j++) if (mt[j] <= t) p++;
    for (int j = mcnt; j > p; j--) begin
      mt[j] = mt[j-1];
      mo[j] = mo[j-1];
    end
    mt[p] = t;
    mo[p] = o;
    mcnt++;
    return p;
  endfunction

  task automatic m_reset();
    mcnt = 0; mbusy = 0; pt = 0; po = 0; pidx = 0;
    for (int o = 0; o < NO; o++) begin xv[o] = 0; xt[o] = 0; end
  endtask

  task automatic m_step(bit a, int at, int ao, bit l, bit d, int dout);
    if (mbusy) begin
      mbusy = 0;
      if (xv[po] && xt[po] > pt) begin
        int disp = xt[po];
        xt[po] = pt;
        m_remove(pidx);
        void'(m_insert(disp, po));
      end
    end else if (a) begin
      if (mcnt < DEPTH) begin
        pidx = m_insert(at, ao);
        pt = at; po = ao; mbusy = 1;
      end
    end else if (l) begin
      for (int j = 0; j < mcnt; j++) begin
        if (!xv[mo[j]]) begin
          xv[mo[j]] = 1;
          xt[mo[j]] = mt[j];
          m_remove(j);
          break;
        end
      end
    end else if (d) begin
      xv[dout] = 0;
    end
  endtask

  task automatic compare(string req);
    bit ok;
    int bad;
    chk(list_cnt == 5'(mcnt), req, "count", int'(list_cnt), mcnt);
    chk(busy == mbusy, "R4", "busy", int'(busy), int'(mbusy));
    for (int o = 0; o < NO; o++) begin
      chk(xp_valid[o] == xv[o], req, $sformatf("xp%0d valid", o), int'(xp_valid[o]), int'(xv[o]));
      if (xv[o])
        chk(int'(xp_dep[o*8 +: 8]) == xt[o], req, $sformatf("xp%0d time", o), int'(xp_dep[o*8 +: 8]), xt[o]);
    end
    ok = 1; bad = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (i < mcnt && (int'(list_dep[i*8 +: 8]) != mt[i] || int'(list_dst[i*2 +: 2]) != mo[i])) begin
        ok = 0; bad = i;
      end
    end
    chk(ok, req, $sformatf("list slot %0d time", bad), int'(list_dep[bad*8 +: 8]), mt[bad]);
    if (!busy) begin
      ok = 1;
      for (int i = 0; i + 1 < int'(list_cnt); i++)
        if (list_dep[i*8 +: 8] > list_dep[(i+1)*8 +: 8]) ok = 0;
      chk(ok, "R2", "list order (1=sorted)", int'(ok), 1);
      ok = 1;
      for (int i = 0; i < int'(list_cnt); i++) begin
        int o = int'(list_dst[i*2 +: 2]);
        if (xp_valid[o] && xp_dep[o*8 +: 8] > list_dep[i*8 +: 8]) ok = 0;
      end
      chk(ok, "R10", "crosspoint bound (1=held)", int'(ok), 1);
    end
  endtask

  task automatic cyc(bit a, int at, int ao, bit l, bit d, int dout, string req);
    @(negedge clk);
    arr_valid = a; arr_dep = 8'(at); arr_dst = 2'(ao);
    load_req = l; drain_req = d; drain_dst = 2'(dout);
    m_step(a, at, ao, l, d, dout);
    @(posedge clk);
    #1;
    arr_valid = 0; load_req = 0; drain_req = 0;
    compare(req);
  endtask

  task automatic arrive(int t, int o, string req);
    cyc(1, t, o, 0, 0, 0, req);
    if (mbusy) cyc(0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    arr_valid = 0; arr_dep = 0; arr_dst = 0; load_req = 0; drain_req = 0; drain_dst = 0;
    rst_n = 0;
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk); rst_n = 1;
    #1;
    compare("R1");

    // sorted insertion with ties (R2)
    arrive(10, 0, "R2");
    arrive(5, 1, "R2");
    arrive(10, 2, "R2");
    arrive(3, 0, "R2");
    arrive(10, 3, "R2");
    // requests during the busy cycle are ignored (R4)
    cyc(1, 20, 1, 0, 0, 0, "R4");
    cyc(1, 1, 1, 1, 1, 0, "R4");
    // loads take head-most tag with a free crosspoint (R7)
    cyc(0, 0, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 0, "R7");
    // urgent arrival exchanges with crosspoint of output 0 (R5)
    arrive(2, 0, "R5");
    arrive(1, 1, "R5");
    // equal and later times leave crosspoint untouched (R6)
    arrive(1, 1, "R6");
    arrive(50, 0, "R6");
    // arrival wins over load in the same cycle (R9)
    cyc(1, 7, 2, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");
    // load wins over drain (R9)
    cyc(0, 0, 0, 1, 1, 0, "R9");
    // drain (R8)
    cyc(0, 0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, 3, "R8");
    // fill the list, then arrivals drop (R3)
    while (mcnt < DEPTH) arrive(int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), "R2");
    cyc(1, 0, 0, 0, 0, 0, "R3");
    cyc(1, 9, 1, 1, 0, 0, "R3");
    // fill all crosspoints, then a load finds nothing eligible (R7)
    for (int k = 0; k < 8; k++) cyc(0, 0, 0, 1, 0, 0, "R7");
    for (int o = 0; o < NO; o++) cyc(0, 0, 0, 0, 1, o, "R8");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 9));
      bit a = (r <= 3);
      bit l = (r >= 4 && r <= 6) || (r == 0);
      bit d = (r >= 6);
      cyc(a, int'($urandom_range(0, 255)), int'($urandom_range(0, 3)), l, d,
          int'($urandom_range(0, 3)), a ? "R5" : (l ? "R7" : "R8"));
    end
    finish_run();
  end

endmodule